// File: doc/BRIEF.md
# Load Miss Replay Controller

This block sits in front of one load port of an out-of-order core. It tracks load micro-ops from their first dispatch until they complete, and it re-sends them to the port when the first-level cache reports a miss. Each load holds one tracking entry. Every dispatch of a load, whether first or repeated, uses exactly one port slot.

The replay policy has two stages. After a first miss, the load is sent again a fixed number of cycles after the dispatch that missed, on the guess that the data will by then come from the second-level cache. If that timed replay also misses, no further timed attempt is made. The entry sleeps until a fill-return event names its tag, and it is then sent one last time. That last send is expected to hit, whatever the latency of the fill was.

Replays and new issues compete for the single port. Replays win. A new issue that loses, or that finds no free entry, sees a stall and must be held by the issuer. A flush empties every entry that has not yet completed in a single cycle.

Top module: `lmr_replay_ctrl`

## Requirements
- R1: Out of reset, every entry is free: `disp_valid`, `cmp_valid` and `iss_stall` are all low while no request is present.
- R2: A new issue is dispatched in the same cycle it is presented when `port_grant` is high, no replay is ready and an entry is free. It goes out with `disp_replay`=0 and `disp_tag` equal to the lowest-numbered free entry.
- R3: A hit response for an entry's dispatch produces one cycle of `cmp_valid`, carrying that entry's tag and load id, in the cycle after the response.
- R4: After a first-dispatch miss, the load is re-dispatched with `disp_replay`=1 exactly REPLAY_DELAY (default 7) cycles after the cycle of the missing dispatch, provided the port is granted.
- R5: A miss on the timed replay puts the entry to sleep. It is not dispatched again until `fill_valid` arrives with its tag, and a fill with any other tag does not wake it. It then replays in the cycle after the fill.
- R6: The replay that follows a fill must hit, and its hit completes the load as in R3.
- R7: When a replay is ready in a cycle with a new issue, the replay takes the port and `iss_stall` is raised. The issue is kept by the issuer and is dispatched in a later cycle.
- R8: Nothing is dispatched while `port_grant` is low. A presented issue sees `iss_stall`=1 in that cycle.
- R9: With all NUM_ENTRIES (default 8) entries busy, a presented issue sees `iss_stall`=1 and is not dispatched.
- R10: `flush` returns every entry that has not completed to free in one cycle, and dispatch is blocked in the flush cycle. An entry that is completing in that cycle still shows `cmp_valid`. No flushed load is replayed later.
- R11: When several replays are ready at the same time, the lowest-numbered entry is dispatched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all entries that have not completed |
| iss_valid | input | 1 | New load presented for issue |
| iss_id | input | ID_W | Opaque identifier of the new load |
| iss_stall | output | 1 | New load not accepted this cycle; hold it |
| port_grant | input | 1 | Load port free for one micro-op this cycle |
| disp_valid | output | 1 | A load is sent to the port this cycle |
| disp_tag | output | log2(NUM_ENTRIES) | Entry of the dispatched load |
| disp_id | output | ID_W | Identifier of the dispatched load |
| disp_replay | output | 1 | Dispatch is a replay rather than a first issue |
| resp_valid | input | 1 | Cache outcome for an earlier dispatch |
| resp_tag | input | log2(NUM_ENTRIES) | Entry the outcome belongs to |
| resp_hit | input | 1 | 1 for hit, 0 for miss |
| fill_valid | input | 1 | Missing data has returned |
| fill_tag | input | log2(NUM_ENTRIES) | Entry the returned data belongs to |
| cmp_valid | output | 1 | A load completes this cycle |
| cmp_tag | output | log2(NUM_ENTRIES) | Entry of the completing load |
| cmp_id | output | ID_W | Identifier of the completing load |

## Verification
The bench counts cycles from the missing dispatch and checks that the timed replay appears in exactly the seventh cycle. A timer that started one edge late, or that counted from the response, would replay one or more cycles off. Through a long quiet period, and across a fill that carries a foreign tag, it checks that a sleeping entry stays silent. A design that kept replaying on the timer, or that woke on any fill, would dispatch there. The bench collides a ready replay with a new issue and blocks the port while two replays ripen together, which catches an inverted priority, a dropped issue and a wrong ordering among entries. It also raises flush while an entry is completing, which catches a flush that swallows the completion or leaves stale entries that replay afterwards.

// File: rtl/lmr_pkg.sv
`timescale 1ns/1ps
package lmr_pkg;

   // Life cycle of one tracked load
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,  // entry free
      ST_WAIT  = 3'd1,  // dispatched, timer running, outcome pending
      ST_SLEEP = 3'd2,  // timed replay missed, waiting for fill
      ST_READY = 3'd3,  // wants the port for a replay
      ST_DONE  = 3'd4   // completing this cycle
   } lmr_state_e;

   // Dispatch count of a load (1 = first, 2 = timed replay, 3 = post-fill replay)
   typedef logic [1:0] lmr_pass_t;

   localparam lmr_pass_t PASS_FIRST = 2'd1;
   localparam lmr_pass_t PASS_TIMED = 2'd2;
   localparam lmr_pass_t PASS_FINAL = 2'd3;

endpackage

// File: rtl/lmr_pick.sv
`timescale 1ns/1ps
module lmr_pick #(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("lmr_pick: N must be at least 2");
   end

   // Lowest set index wins
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/lmr_entry.sv
`timescale 1ns/1ps
module lmr_entry
   import lmr_pkg::*;
#(
   parameter int ID_W         = 6,
   parameter int REPLAY_DELAY = 7,
   localparam int TMR_W = $clog2(REPLAY_DELAY + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            alloc,
   input  logic [ID_W-1:0] alloc_id,
   input  logic            grant,
   input  logic            resp_v,
   input  logic            resp_hit,
   input  logic            fill_v,
   output lmr_state_e      state,
   output logic [ID_W-1:0] id
);

   if (REPLAY_DELAY < 2) begin : g_bad_delay
      $error("lmr_entry: REPLAY_DELAY must be at least 2");
   end

   localparam logic [TMR_W-1:0] TMR_ONE  = TMR_W'(1);
   localparam logic [TMR_W-1:0] TMR_FIRE = TMR_W'(REPLAY_DELAY - 1);
   localparam logic [TMR_W-1:0] TMR_MAX  = TMR_W'(REPLAY_DELAY);

   logic [TMR_W-1:0] timer;   // cycles since the last dispatch
   lmr_pass_t        pass;
   logic             missed;  // first dispatch reported a miss

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         id     <= '0;
         timer  <= '0;
         pass   <= '0;
         missed <= 1'b0;
      end else if (flush && state != ST_DONE) begin
         state  <= ST_IDLE;
         timer  <= '0;
         pass   <= '0;
         missed <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (alloc) begin
                  state  <= ST_WAIT;
                  id     <= alloc_id;
                  pass   <= PASS_FIRST;
                  timer  <= TMR_ONE;
                  missed <= 1'b0;
               end
            end
            ST_WAIT: begin
               if (timer != TMR_MAX) timer <= timer + 1'b1;
               if (resp_v && resp_hit) begin
                  state <= ST_DONE;
               end else if (resp_v && pass != PASS_FIRST) begin
                  state <= ST_SLEEP;
               end else if ((missed || resp_v) && timer >= TMR_FIRE) begin
                  state <= ST_READY;
               end else if (resp_v) begin
                  missed <= 1'b1;
               end
            end
            ST_READY: begin
               if (grant) begin
                  state  <= ST_WAIT;
                  pass   <= pass + 1'b1;
                  timer  <= TMR_ONE;
                  missed <= 1'b0;
               end
            end
            ST_SLEEP: begin
               if (fill_v) state <= ST_READY;
            end
            ST_DONE: begin
               state <= ST_IDLE;
               pass  <= '0;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R6: the replay after a fill must not miss
   a_r6_final_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && pass == PASS_FINAL && resp_v) |-> resp_hit);

   // R5: a miss on the timed replay puts the entry to sleep
   a_r5_sleep_after_timed_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && pass == PASS_TIMED && resp_v && !resp_hit && !flush)
      |=> state == ST_SLEEP);

   // R5: a sleeping entry only wakes on its own fill
   a_r5_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLEEP && !fill_v && !flush) |=> state == ST_SLEEP);

   // R4: a timed replay never becomes ready before the delay has run
   a_r4_not_early: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READY && $past(state) == ST_WAIT) |-> $past(timer) >= TMR_FIRE);

   // R10: flush frees any entry not completing
   a_r10_flush_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && state != ST_DONE) |=> state == ST_IDLE);

   // R3: completion lasts one cycle
   a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |=> state == ST_IDLE);

endmodule

// File: rtl/lmr_replay_ctrl.sv
`timescale 1ns/1ps
module lmr_replay_ctrl
   import lmr_pkg::*;
#(
   parameter int NUM_ENTRIES  = 8,
   parameter int ID_W         = 6,
   parameter int REPLAY_DELAY = 7,
   localparam int TAG_W = $clog2(NUM_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             iss_valid,
   input  logic [ID_W-1:0]  iss_id,
   output logic             iss_stall,
   input  logic             port_grant,
   output logic             disp_valid,
   output logic [TAG_W-1:0] disp_tag,
   output logic [ID_W-1:0]  disp_id,
   output logic             disp_replay,
   input  logic             resp_valid,
   input  logic [TAG_W-1:0] resp_tag,
   input  logic             resp_hit,
   input  logic             fill_valid,
   input  logic [TAG_W-1:0] fill_tag,
   output logic             cmp_valid,
   output logic [TAG_W-1:0] cmp_tag,
   output logic [ID_W-1:0]  cmp_id
);

   if (NUM_ENTRIES < 2 || (1 << TAG_W) != NUM_ENTRIES) begin : g_bad_entries
      $error("lmr_replay_ctrl: NUM_ENTRIES must be a power of two, at least 2");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("lmr_replay_ctrl: ID_W must be positive");
   end

   lmr_state_e           ent_st [NUM_ENTRIES];
   logic [ID_W-1:0]      ent_id [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] ready_vec, free_vec, done_vec;

   logic             any_ready, any_free, any_done;
   logic [TAG_W-1:0] rdy_idx, free_idx, done_idx;
   logic             rep_go, new_go;

   lmr_pick #(.N(NUM_ENTRIES)) u_pick_ready (.req(ready_vec), .any(any_ready), .idx(rdy_idx));
   lmr_pick #(.N(NUM_ENTRIES)) u_pick_free  (.req(free_vec),  .any(any_free),  .idx(free_idx));
   lmr_pick #(.N(NUM_ENTRIES)) u_pick_done  (.req(done_vec),  .any(any_done),  .idx(done_idx));

   // Port arbitration: replay before new issue, nothing during flush
   assign rep_go = port_grant && !flush && any_ready;
   assign new_go = port_grant && !flush && !any_ready && iss_valid && any_free;

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      logic alloc_g, grant_g, resp_g, fill_g;
      assign alloc_g = new_go && (free_idx == TAG_W'(g));
      assign grant_g = rep_go && (rdy_idx == TAG_W'(g));
      assign resp_g  = resp_valid && (resp_tag == TAG_W'(g));
      assign fill_g  = fill_valid && (fill_tag == TAG_W'(g));

      lmr_entry #(
         .ID_W        (ID_W),
         .REPLAY_DELAY(REPLAY_DELAY)
      ) u_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .alloc    (alloc_g),
         .alloc_id (iss_id),
         .grant    (grant_g),
         .resp_v   (resp_g),
         .resp_hit (resp_hit),
         .fill_v   (fill_g),
         .state    (ent_st[g]),
         .id       (ent_id[g])
      );

      assign ready_vec[g] = (ent_st[g] == ST_READY);
      assign free_vec[g]  = (ent_st[g] == ST_IDLE);
      assign done_vec[g]  = (ent_st[g] == ST_DONE);
   end

   assign disp_valid  = rep_go || new_go;
   assign disp_replay = rep_go;
   assign disp_tag    = rep_go ? rdy_idx : free_idx;
   assign disp_id     = rep_go ? ent_id[rdy_idx] : iss_id;
   assign iss_stall   = iss_valid && !new_go;

   assign cmp_valid = any_done;
   assign cmp_tag   = done_idx;
   assign cmp_id    = ent_id[done_idx];

   // R8: one micro-op per granted cycle
   a_r8_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> port_grant);

   // R7: a ready replay always takes a granted port
   a_r7_replay_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (port_grant && !flush && |ready_vec) |-> (disp_valid && disp_replay));

   // R7: a new issue that loses to a replay is stalled, not dropped
   a_r7_stall_not_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && disp_replay) |-> iss_stall);

   // R9: no acceptance when every entry is busy
   a_r9_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && free_vec == '0) |-> iss_stall);

   // R3: at most one completion per cycle
   a_r3_single_done: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_vec));

   // R10: nothing goes to the port in a flush cycle
   a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !disp_valid);

endmodule

// File: tb/lmr_replay_ctrl_tb_top.sv
`timescale 1ns/1ps
module lmr_replay_ctrl_tb_top;

   localparam int N     = 8;
   localparam int ID_W  = 6;
   localparam int DLY   = 7;
   localparam int TAG_W = 3;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             flush;
   logic             iss_valid;
   logic [ID_W-1:0]  iss_id;
   logic             iss_stall;
   logic             port_grant;
   logic             disp_valid;
   logic [TAG_W-1:0] disp_tag;
   logic [ID_W-1:0]  disp_id;
   logic             disp_replay;
   logic             resp_valid;
   logic [TAG_W-1:0] resp_tag;
   logic             resp_hit;
   logic             fill_valid;
   logic [TAG_W-1:0] fill_tag;
   logic             cmp_valid;
   logic [TAG_W-1:0] cmp_tag;
   logic [ID_W-1:0]  cmp_id;

   int n_chk  = 0;
   int n_fail = 0;
   bit done_run = 1'b0;

   always #2.5 clk = ~clk;

   lmr_replay_ctrl #(.NUM_ENTRIES(N), .ID_W(ID_W), .REPLAY_DELAY(DLY)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .iss_valid(iss_valid), .iss_id(iss_id), .iss_stall(iss_stall),
      .port_grant(port_grant),
      .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_id(disp_id),
      .disp_replay(disp_replay),
      .resp_valid(resp_valid), .resp_tag(resp_tag), .resp_hit(resp_hit),
      .fill_valid(fill_valid), .fill_tag(fill_tag),
      .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_id(cmp_id)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Advance to the next cycle and return inputs to their idle values
   task automatic cyc();
      @(negedge clk);
      flush = 1'b0; iss_valid = 1'b0; iss_id = '0; port_grant = 1'b1;
      resp_valid = 1'b0; resp_tag = '0; resp_hit = 1'b0;
      fill_valid = 1'b0; fill_tag = '0;
   endtask

   task automatic do_reset();
      cyc();
      rst_n = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      cyc(); #1;
      chk("R1 disp_valid", 32'(disp_valid), 0);
      chk("R1 cmp_valid",  32'(cmp_valid), 0);
      chk("R1 iss_stall",  32'(iss_stall), 0);
   endtask

   task automatic t_hit();
      do_reset();
      cyc(); iss_valid = 1; iss_id = 6'h11; #1;
      chk("R2 dispatch", {disp_valid, disp_replay, iss_stall, 5'(disp_tag)}, {3'b100, 5'd0});
      cyc();
      cyc(); resp_valid = 1; resp_tag = 0; resp_hit = 1; #1;
      cyc(); #1;
      chk("R3 completion", {cmp_valid, 5'(cmp_tag), 8'(cmp_id)}, {1'b1, 5'd0, 8'h11});
      cyc(); #1;
      chk("R3 single pulse", 32'(cmp_valid), 0);
   endtask

   task automatic t_miss_chain();
      int quiet_bad;
      do_reset();
      cyc(); iss_valid = 1; iss_id = 6'h22; #1;          // cycle 0
      chk("R2 first dispatch", 32'(disp_valid), 1);
      cyc();                                              // cycle 1
      cyc(); resp_valid = 1; resp_tag = 0; resp_hit = 0;  // cycle 2 miss
      #1;
      quiet_bad = 0;
      for (int c = 3; c < DLY; c++) begin
         cyc(); #1;
         if (disp_valid) quiet_bad++;
      end
      chk("R4 no early replay", 32'(quiet_bad), 0);
      cyc(); #1;                                          // cycle 7
      chk("R4 timed replay", {disp_valid, disp_replay, 5'(disp_tag), 8'(disp_id)},
          {2'b11, 5'd0, 8'h22});
      cyc();                                              // cycle 8
      cyc(); resp_valid = 1; resp_tag = 0; resp_hit = 0;  // cycle 9 second miss
      #1;
      quiet_bad = 0;
      for (int c = 10; c < 25; c++) begin
         cyc();
         if (c == 15) begin fill_valid = 1; fill_tag = 3'd3; end
         #1;
         if (disp_valid) quiet_bad++;
      end
      chk("R5 sleeps until own fill", 32'(quiet_bad), 0);
      cyc(); fill_valid = 1; fill_tag = 0; #1;            // cycle 25
      chk("R5 no dispatch in fill cycle", 32'(disp_valid), 0);
      cyc(); #1;                                          // cycle 26
      chk("R5 replay after fill", {disp_valid, disp_replay, 5'(disp_tag)}, {2'b11, 5'd0});
      cyc();
      cyc(); resp_valid = 1; resp_tag = 0; resp_hit = 1; #1;
      cyc(); #1;
      chk("R6 final completion", {cmp_valid, 8'(cmp_id)}, {1'b1, 8'h22});
   endtask

   task automatic t_priority();
      do_reset();
      cyc(); iss_valid = 1; iss_id = 6'h01; #1;
      cyc();
      cyc(); resp_valid = 1; resp_tag = 0; resp_hit = 0;
      for (int c = 3; c < DLY; c++) cyc();
      cyc(); iss_valid = 1; iss_id = 6'h02; #1;           // cycle 7
      chk("R7 replay wins", {disp_valid, disp_replay, iss_stall, 5'(disp_tag)},
          {3'b111, 5'd0});
      cyc(); iss_valid = 1; iss_id = 6'h02; #1;           // cycle 8
      chk("R7 stalled issue later", {disp_valid, disp_replay, iss_stall, 5'(disp_tag), 8'(disp_id)},
          {3'b100, 5'd1, 8'h02});
   endtask

   task automatic t_order();
      do_reset();
      cyc(); iss_valid = 1; iss_id = 6'h03; #1;           // cycle 0, tag 0
      cyc(); iss_valid = 1; iss_id = 6'h04; #1;           // cycle 1, tag 1
      chk("R2 lowest free", 32'(disp_tag), 1);
      cyc(); resp_valid = 1; resp_tag = 0; resp_hit = 0;  // cycle 2
      cyc(); resp_valid = 1; resp_tag = 1; resp_hit = 0;  // cycle 3
      for (int c = 4; c < DLY; c++) cyc();
      cyc(); port_grant = 0; iss_valid = 1; iss_id = 6'h05; #1;   // cycle 7
      chk("R8 no grant", {disp_valid, iss_stall}, 2'b01);
      cyc(); #1;                                          // cycle 8
      chk("R11 lowest ready first", {disp_valid, disp_replay, 5'(disp_tag)}, {2'b11, 5'd0});
      cyc(); #1;                                          // cycle 9
      chk("R11 next ready", {disp_valid, disp_replay, 5'(disp_tag)}, {2'b11, 5'd1});
   endtask

   task automatic t_full_flush();
      int quiet_bad;
      do_reset();
      for (int i = 0; i < N; i++) begin
         cyc(); iss_valid = 1; iss_id = ID_W'(6'h30 + i); #1;
         chk("R2 fill entries", {disp_valid, 5'(disp_tag)}, {1'b1, 5'(i)});
      end
      cyc(); iss_valid = 1; iss_id = 6'h3e;               // cycle 8
      resp_valid = 1; resp_tag = 2; resp_hit = 1; #1;
      chk("R9 full stalls", {disp_valid, iss_stall}, 2'b01);
      cyc(); flush = 1; iss_valid = 1; iss_id = 6'h3e; #1; // cycle 9
      chk("R10 completion survives flush", {cmp_valid, 5'(cmp_tag), 8'(cmp_id)},
          {1'b1, 5'd2, 8'h32});
      chk("R10 no dispatch in flush", {disp_valid, iss_stall}, 2'b01);
      cyc(); iss_valid = 1; iss_id = 6'h3f; fill_valid = 1; fill_tag = 3'd5; #1;
      chk("R10 entries freed", {disp_valid, disp_replay, 5'(disp_tag), cmp_valid},
          {2'b10, 5'd0, 1'b0});
      quiet_bad = 0;
      for (int c = 0; c < 12; c++) begin
         cyc(); #1;
         if (disp_valid) quiet_bad++;
      end
      chk("R10 no stale replay", 32'(quiet_bad), 0);
   endtask

   initial begin
      rst_n = 1'b0;
      flush = 1'b0; iss_valid = 1'b0; iss_id = '0; port_grant = 1'b1;
      resp_valid = 1'b0; resp_tag = '0; resp_hit = 1'b0;
      fill_valid = 1'b0; fill_tag = '0;
      t_reset();
      t_hit();
      t_miss_chain();
      t_priority();
      t_order();
      t_full_flush();
      done_run = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_run) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule